// File: doc/BRIEF.md
# Iterative Restoring Unsigned Divider

This block divides one unsigned integer by another, one quotient bit per clock. When `start` is seen while the unit is idle, it captures both operands. It places the divisor `W` bit positions above its true weight in a wide register. The quotient starts at zero and the running remainder starts at the dividend. On every iteration the unit does three things:

- It shifts the quotient left.
- It forms the difference between the remainder and the scaled divisor, and reads the sign bit of that difference. When the sign is clear, the divisor fits: the remainder takes the difference and the new quotient LSB is 1.
- It shifts the divisor one place right.

There are `W+1` iterations. After the last one the unit pulses `done` and keeps the results until the next accepted start.

A controller with three named states sequences the work:

- **IDLE**: waiting. IDLE→ITER when `start` is high; the operands are loaded on that edge.
- **ITER**: one iteration per cycle, with `busy` high. ITER→ITER while the step count is below `W`. ITER→DONE on the iteration whose count equals `W`.
- **DONE**: `done` high for a single cycle. DONE→IDLE unconditionally.

A zero divisor needs no special path. The scaled divisor is zero, so every fit test succeeds. The quotient fills with ones and the remainder stays at the dividend. A flag captured at load reports the case.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0.
- R2: A start seen at a clock edge in IDLE is accepted. `busy` goes high after that edge and stays high for exactly W+1 = 33 cycles.
- R3: `done` is high for exactly one cycle, the cycle right after `busy` falls. `busy` and `done` are never high together.
- R4: With a nonzero divisor, while `done` is high, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor, for the operands captured at the accepted start.
- R5: With a zero divisor the operation takes the same time. `quotient` is all ones, `remainder` equals the dividend and `div_by_zero` is 1. `div_by_zero` is 0 after any operation with a nonzero divisor.
- R6: A start seen while `busy` or `done` is high is ignored. The operation in progress finishes with its own results, and no new operation begins.
- R7: In IDLE after an operation, `quotient`, `remainder` and `div_by_zero` keep their final values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; sampled only in IDLE |
| dividend | input | 32 | Unsigned dividend |
| divisor | input | 32 | Unsigned divisor |
| busy | output | 1 | High during the W+1 iteration cycles |
| done | output | 1 | One-cycle pulse when results are final |
| quotient | output | 32 | Unsigned quotient |
| remainder | output | 32 | Unsigned remainder |
| div_by_zero | output | 1 | Last accepted divisor was zero |

## Verification
The hardest case to reach from the ports is a start that arrives in the single DONE cycle. That cycle is the only non-idle moment that follows a finished result, and an accepted start there would corrupt the result just presented. The stimulus therefore waits for the negative edge where `done` is high and raises `start` there with fresh operands. A second injection raises `start` in the middle of an iteration run. Separately, the operand set covers the two extremes of the fit test: a divisor of one, where every iteration after the first fits, and a zero divisor, where every iteration fits.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_DONE = 2'd2
    } rdiv_state_e;
endpackage

// File: rtl/rdiv_ctrl.sv
`timescale 1ns/1ps
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] LAST = CW'(W);

    rdiv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ITER;
            ST_ITER: if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_ITER);
        busy = (state_q == ST_ITER);
        done = (state_q == ST_DONE);
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q <= LAST));
    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

// File: rtl/rdiv_datapath.sv
`timescale 1ns/1ps
module rdiv_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    localparam int WW = 2 * W + 1;

    logic [WW-1:0] div_q, rem_q, diff;
    logic [W-1:0]  quo_q;
    logic          dz_q;
    logic          fits;

    always_comb begin
        diff = rem_q - div_q;
        fits = ~diff[WW-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            dz_q  <= 1'b0;
        end else if (load) begin
            div_q <= {1'b0, divisor, {W{1'b0}}};
            rem_q <= {{(W+1){1'b0}}, dividend};
            quo_q <= '0;
            dz_q  <= (divisor == '0);
        end else if (step) begin
            quo_q <= {quo_q[W-2:0], fits};
            if (fits) rem_q <= diff;
            div_q <= div_q >> 1;
        end
    end

    assign quotient    = quo_q;
    assign remainder   = rem_q[W-1:0];
    assign div_by_zero = dz_q;

    // R4
    rem_nonincrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q <= $past(rem_q)));
    // R4
    div_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (div_q == ($past(div_q) >> 1)));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(quo_q) && $stable(rem_q) && $stable(dz_q)));
endmodule

// File: rtl/restoring_divider.sv
`timescale 1ns/1ps
module restoring_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    logic load, step;

    rdiv_ctrl #(.W(W)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    rdiv_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .dividend   (dividend),
        .divisor    (divisor),
        .quotient   (quotient),
        .remainder  (remainder),
        .div_by_zero(div_by_zero)
    );

    // R5
    dz_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '1));
endmodule

// File: tb/restoring_divider_bench.sv
`timescale 1ns/1ps
module restoring_divider_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    restoring_divider #(.W(W)) u_restoring_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero)
    );

    // behavioural reference model
    bit           m_busy, m_done, m_have;
    int           m_left;
    logic [W-1:0] e_q, e_r;
    bit           e_z;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_have <= 0; m_left <= 0;
            e_q <= '0; e_r <= '0; e_z <= 0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_left == 1) begin m_busy <= 0; m_done <= 1; end
                m_left <= m_left - 1;
            end else if (m_done) begin
                m_have <= 1;
            end else if (start) begin
                m_busy <= 1;
                m_left <= W + 1;
                m_have <= 0;
                e_z <= (divisor == 0);
                e_q <= (divisor == 0) ? '1 : dividend / divisor;
                e_r <= (divisor == 0) ? dividend : dividend % divisor;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(busy == 0 && done == 0 && div_by_zero == 0, "R1", "flags", {busy, done, div_by_zero}, 0);
            chk(quotient == 0 && remainder == 0, "R1", "results", quotient | remainder, 0);
        end else begin
            chk(busy == m_busy, "R2", "busy", busy, m_busy);
            chk(done == m_done, "R3", "done", done, m_done);
            if (m_done) begin
                if (e_z) begin
                    chk(quotient == e_q, "R5", "quotient", quotient, e_q);
                    chk(remainder == e_r, "R5", "remainder", remainder, e_r);
                    chk(div_by_zero == 1, "R5", "flag", div_by_zero, 1);
                end else begin
                    chk(quotient == e_q, "R4", "quotient", quotient, e_q);
                    chk(remainder == e_r, "R4", "remainder", remainder, e_r);
                    chk(div_by_zero == 0, "R5", "flag", div_by_zero, 0);
                end
            end else if (!m_busy && m_have) begin
                chk(quotient == e_q, "R7", "held quotient", quotient, e_q);
                chk(remainder == e_r, "R7", "held remainder", remainder, e_r);
                chk(div_by_zero == e_z, "R7", "held flag", div_by_zero, e_z);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic divide(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = ~a; divisor = ~b;
        wait_done();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R4: assorted patterns
        divide(32'd78, 32'd21);
        divide(32'd1000, 32'd10);
        divide(32'd5, 32'd9);
        divide(32'hFFFF_FFFF, 32'd1);
        divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        divide(32'h8000_0000, 32'h8000_0001);
        divide(32'hDEAD_BEEF, 32'h0000_1234);
        divide(32'h1234_5678, 32'h0000_0007);
        divide(32'd0, 32'd3);
        // R5: zero divisor
        divide(32'hCAFE_F00D, 32'd0);
        divide(32'd0, 32'd0);
        divide(32'd100, 32'd7);
        // R6: start mid-run ignored
        @(negedge clk);
        dividend = 32'd999; divisor = 32'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        dividend = 32'd50; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(quotient == 32'd249 && remainder == 32'd3, "R6", "mid-run start", quotient, 32'd249);
        // R6: start during the done cycle ignored
        dividend = 32'd7; divisor = 32'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 0, "R6", "start in done cycle", busy, 0);
        repeat (4) @(negedge clk);
        chk(quotient == 32'd249, "R6", "result after done-cycle start", quotient, 32'd249);
        // back-to-back after idle
        divide(32'h7FFF_FFFF, 32'h0001_0000);
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule